// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit processor data path. Each cycle it takes one operand, a shift-kind code, an 8-bit amount and the current carry flag. It returns the shifted value and the carry-out that the flag logic would record. The kinds are logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. Amounts of zero, exactly the data width, and above the data width follow fixed architectural rules rather than a plain shift.

The shift itself is combinational. It is built from one shared logarithmic rotator, an amount classifier and a per-kind mask-and-select stage. By default, an output register captures the result whenever `valid_i` is high. It raises `valid_o` one cycle later and holds its value while `valid_i` is low. Setting `REG_OUT` to 0 removes the register and passes the result straight through.

Top module: `bshift_top`

## Requirements
- R1: `kind_i` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate right through carry. Codes 5 to 7 return the operand unchanged with carry-out equal to `carry_i`.
- R2: For kinds 0 to 3 with `amount_i` equal to 0, the result is the operand and the carry-out equals `carry_i`.
- R3: Logical left by n, for n from 1 to 31, gives operand << n with carry-out equal to operand bit (32-n). With n = 32, the result is 0 and the carry-out is operand bit 0.
- R4: Logical right by n, for n from 1 to 31, gives operand >> n with carry-out equal to operand bit (n-1). With n = 32, the result is 0 and the carry-out is operand bit 31.
- R5: Logical left or logical right by more than 32 gives result 0 and carry-out 0.
- R6: Arithmetic right by n, for n from 1 to 31, fills the vacated upper bits with operand bit 31, and the carry-out is operand bit (n-1). For n of 32 or more, every result bit and the carry-out equal operand bit 31.
- R7: Rotate right by a non-zero amount rotates by the amount modulo 32, so 32 and 64 return the operand. The carry-out equals result bit 31.
- R8: Rotate through carry returns {carry_i, operand[31:1]} with carry-out equal to operand bit 0. `amount_i` has no effect on this kind.
- R9: With `REG_OUT` = 1, `result_o` and `carry_o` show the result for inputs presented with `valid_i` high one cycle later, and `valid_o` then reads 1. While `valid_i` is low the outputs hold and `valid_o` reads 0. In reset all three outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs carry a request this cycle |
| operand_i | input | 32 | Value to shift |
| kind_i | input | 3 | Shift-kind code (see R1) |
| amount_i | input | 8 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result registers hold a fresh result |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The block holds no state apart from the output register, so any fault in the rotator, classifier or masks shows at `result_o`/`carry_o` in the cycle right after the request. A broken rotator stage corrupts only amounts that have the matching bit set. The sweep therefore covers every amount from 0 to 40 on operands with distinct bit patterns. A misclassified amount shows only at the edges 0, 31, 32 and 33 and at large values. A wrong enable or valid path shows as an output that changes, or a `valid_o` that stays high, on the cycle after `valid_i` drops.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/bshift_amt_class.sv
module bshift_amt_class #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [AW-1:0] amt_i,
  output logic          zero_o,
  output logic          below_o,
  output logic          equal_o,
  output logic          above_o,
  output logic [SW-1:0] mod_o
);
  localparam logic [AW-1:0] AMT_DW = AW'(DW);

  assign zero_o  = (amt_i == '0);
  assign below_o = !zero_o && (amt_i < AMT_DW);
  assign equal_o = (amt_i == AMT_DW);
  assign above_o = (amt_i > AMT_DW);
  assign mod_o   = amt_i[SW-1:0];
endmodule

// File: rtl/bshift_rotr.sv
module bshift_rotr #(
  parameter int unsigned DW = 32,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] amt_i,
  output logic [DW-1:0] rot_o
);
  logic [SW:0][DW-1:0] stg;

  assign stg[0] = data_i;

  // one stage per amount bit, stage s rotates by 2**s
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stg[s+1] = amt_i[s] ? {stg[s][SH-1:0], stg[s][DW-1:SH]} : stg[s];
  end

  assign rot_o = stg[SW];
endmodule

// File: rtl/bshift_select.sv
module bshift_select
  import bshift_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] op_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  logic          a_zero, a_below, a_equal, a_above;
  logic [SW-1:0] a_mod;
  logic [SW-1:0] idx_r, idx_l, rot_amt;
  logic [DW-1:0] rot, hi_mask, lo_mask, sign_fill;
  shift_kind_e   kind;
  logic          sgn;

  assign kind = shift_kind_e'(kind_i);
  assign sgn  = op_i[DW-1];

  bshift_amt_class #(.DW(DW), .AW(AW)) u_class (
    .amt_i  (amt_i),
    .zero_o (a_zero),
    .below_o(a_below),
    .equal_o(a_equal),
    .above_o(a_above),
    .mod_o  (a_mod)
  );

  // left shift reuses the right rotator with the complementary amount
  assign idx_r   = a_mod - SW'(1);
  assign idx_l   = SW'(0) - a_mod;
  assign rot_amt = (kind == SK_LSL) ? idx_l : a_mod;

  bshift_rotr #(.DW(DW)) u_rot (
    .data_i(op_i),
    .amt_i (rot_amt),
    .rot_o (rot)
  );

  assign hi_mask   = ~({DW{1'b1}} >> a_mod);
  assign lo_mask   = ~({DW{1'b1}} << a_mod);
  assign sign_fill = sgn ? hi_mask : '0;

  always_comb begin
    res_o  = op_i;
    cout_o = cin_i;
    unique case (kind)
      SK_LSL: begin
        if (a_below) begin
          res_o  = rot & ~lo_mask;
          cout_o = op_i[idx_l];
        end else if (a_equal) begin
          res_o  = '0;
          cout_o = op_i[0];
        end else if (a_above) begin
          res_o  = '0;
          cout_o = 1'b0;
        end
      end
      SK_LSR: begin
        if (a_below) begin
          res_o  = rot & ~hi_mask;
          cout_o = op_i[idx_r];
        end else if (a_equal) begin
          res_o  = '0;
          cout_o = sgn;
        end else if (a_above) begin
          res_o  = '0;
          cout_o = 1'b0;
        end
      end
      SK_ASR: begin
        if (a_below) begin
          res_o  = (rot & ~hi_mask) | sign_fill;
          cout_o = op_i[idx_r];
        end else if (!a_zero) begin
          res_o  = {DW{sgn}};
          cout_o = sgn;
        end
      end
      SK_ROR: begin
        if (!a_zero) begin
          res_o  = rot;
          cout_o = rot[DW-1];
        end
      end
      SK_RRX: begin
        res_o  = {cin_i, op_i[DW-1:1]};
        cout_o = op_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [31:0]   operand_i,
  input  logic [2:0]    kind_i,
  input  logic [7:0]    amount_i,
  input  logic          carry_i,
  output logic          valid_o,
  output logic [31:0]   result_o,
  output logic          carry_o
);
  localparam logic [AW-1:0] AMT_DW = AW'(DW);

  logic [DW-1:0] core_res;
  logic          core_c;

  bshift_select #(.DW(DW), .AW(AW)) u_sel (
    .op_i  (DW'(operand_i)),
    .kind_i(kind_i),
    .amt_i (AW'(amount_i)),
    .cin_i (carry_i),
    .res_o (core_res),
    .cout_o(core_c)
  );

  if (REG_OUT) begin : g_reg
    logic          vld_q;
    logic [DW-1:0] res_q;
    logic          c_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        res_q <= '0;
        c_q   <= 1'b0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) begin
          res_q <= core_res;
          c_q   <= core_c;
        end
      end
    end

    assign valid_o  = vld_q;
    assign result_o = 32'(res_q);
    assign carry_o  = c_q;

    // R9
    valid_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $past(valid_i));
    // R9
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(valid_i) |-> ($stable(result_o) && $stable(carry_o)));
  end else begin : g_comb
    assign valid_o  = valid_i;
    assign result_o = 32'(core_res);
    assign carry_o  = core_c;
  end

  // R2
  zero_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amount_i == '0 && kind_i <= 3'(SK_ROR))
      |-> (core_res == DW'(operand_i) && core_c == carry_i));
  // R5
  over_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && AW'(amount_i) > AMT_DW && (kind_i == 3'(SK_LSL) || kind_i == 3'(SK_LSR)))
      |-> (core_res == '0 && !core_c));
  // R6
  asr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 3'(SK_ASR) && AW'(amount_i) >= AMT_DW)
      |-> (core_res == {DW{operand_i[DW-1]}} && core_c == operand_i[DW-1]));
  // R7
  ror_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 3'(SK_ROR) && amount_i != '0)
      |-> (core_c == core_res[DW-1]));
  // R8
  rrx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 3'(SK_RRX))
      |-> (core_res == {carry_i, operand_i[DW-1:1]} && core_c == operand_i[0]));
  // R1
  spare_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i > 3'(SK_RRX))
      |-> (core_res == DW'(operand_i) && core_c == carry_i));
endmodule

// File: tb/sim_bshift_top.sv
module sim_bshift_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [2:0]  kind_i = '0;
  logic [7:0]  amount_i = '0;
  logic        carry_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        carry_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  bshift_top u0 (
    .clk_i, .rst_ni, .valid_i, .operand_i, .kind_i, .amount_i, .carry_i,
    .valid_o, .result_o, .carry_o
  );

  // {kind, amount, carry_in, operand, expected result, expected carry}
  localparam int NV = 17;
  localparam logic [76:0] VEC [NV] = '{
    {3'd0, 8'd4,   1'b0, 32'h12345678, 32'h23456780, 1'b1},
    {3'd0, 8'd0,   1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1},
    {3'd0, 8'd32,  1'b0, 32'h00000001, 32'h00000000, 1'b1},
    {3'd0, 8'd33,  1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0},
    {3'd1, 8'd1,   1'b0, 32'h00000003, 32'h00000001, 1'b1},
    {3'd1, 8'd32,  1'b0, 32'h80000000, 32'h00000000, 1'b1},
    {3'd1, 8'd40,  1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0},
    {3'd2, 8'd4,   1'b1, 32'h80000010, 32'hF8000001, 1'b0},
    {3'd2, 8'd255, 1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b1},
    {3'd2, 8'd32,  1'b1, 32'h7FFFFFFF, 32'h00000000, 1'b0},
    {3'd3, 8'd8,   1'b1, 32'h12345678, 32'h78123456, 1'b0},
    {3'd3, 8'd36,  1'b0, 32'h00000008, 32'h80000000, 1'b1},
    {3'd3, 8'd32,  1'b0, 32'h80000000, 32'h80000000, 1'b1},
    {3'd3, 8'd0,   1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0},
    {3'd4, 8'd0,   1'b1, 32'h00000003, 32'h80000001, 1'b1},
    {3'd4, 8'd5,   1'b0, 32'h00000002, 32'h00000001, 1'b0},
    {3'd6, 8'd3,   1'b1, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b1}
  };

  function automatic string tag_of(logic [2:0] k, logic [7:0] a);
    if (k > 3'd4)             return "R1";
    if (k < 3'd4 && a == 8'd0) return "R2";
    case (k)
      3'd0:    return (a > 8'd32) ? "R5" : "R3";
      3'd1:    return (a > 8'd32) ? "R5" : "R4";
      3'd2:    return "R6";
      3'd3:    return "R7";
      default: return "R8";
    endcase
  endfunction

  // reference model built on wide shifts, independent of the rotator structure
  task automatic ref_model(input logic [2:0] k, input logic [7:0] a, input logic ci,
                           input logic [31:0] op, output logic [31:0] r, output logic c);
    logic [64:0] w;
    logic [63:0] d;
    r = op;
    c = ci;
    case (k)
      3'd0: if (a != 0) begin w = {33'b0, op} << a; r = w[31:0]; c = w[32]; end
      3'd1: if (a != 0) begin w = {op, 33'b0} >> a; r = w[64:33]; c = w[32]; end
      3'd2: if (a != 0) begin w = $signed({op, 33'b0}) >>> a; r = w[64:33]; c = w[32]; end
      3'd3: if (a != 0) begin d = {op, op} >> (a % 32); r = d[31:0]; c = r[31]; end
      3'd4: begin r = {ci, op[31:1]}; c = op[0]; end
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic exp_v, logic [31:0] exp_r, logic exp_c);
    n_vec++;
    if (valid_o !== exp_v || result_o !== exp_r || carry_o !== exp_c) begin
      n_bad++;
      $display("FAIL %s: got v=%b r=%h c=%b, expected v=%b r=%h c=%b",
               tag, valid_o, result_o, carry_o, exp_v, exp_r, exp_c);
    end
  endtask

  task automatic apply(logic [2:0] k, logic [7:0] a, logic ci, logic [31:0] op,
                       logic [31:0] exp_r, logic exp_c);
    @(negedge clk_i);
    valid_i = 1'b1; kind_i = k; amount_i = a; carry_i = ci; operand_i = op;
    @(negedge clk_i);
    check(tag_of(k, a), 1'b1, exp_r, exp_c);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] er;
    logic        ec;
    logic [31:0] ops [4] = '{32'h12345678, 32'h80000001, 32'hF0F0A5C3, 32'h00000000};
    logic [7:0]  big [6] = '{8'd63, 8'd64, 8'd65, 8'd128, 8'd200, 8'd255};

    // R9: reset state
    repeat (2) @(negedge clk_i);
    check("R9", 1'b0, 32'h0, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(VEC[i][76:74], VEC[i][73:66], VEC[i][65], VEC[i][64:33], VEC[i][32:1], VEC[i][0]);

    // R9: outputs hold while valid_i is low
    @(negedge clk_i);
    valid_i = 1'b0; kind_i = 3'd4; operand_i = 32'h55555555; carry_i = 1'b0;
    @(negedge clk_i);
    check("R9", 1'b0, 32'hA5A5A5A5, 1'b1);
    @(negedge clk_i);
    check("R9", 1'b0, 32'hA5A5A5A5, 1'b1);

    // R8: amount has no effect on rotate through carry
    for (int a = 0; a < 256; a += 51) begin
      apply(3'd4, 8'(a), 1'b1, 32'h0000000E, 32'h80000007, 1'b0);
    end

    // sweep: all kinds, amounts 0..40 and large values
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 8; k++) begin
        for (int a = 0; a < 47; a++) begin
          logic [7:0] amt;
          logic       ci;
          amt = (a < 41) ? 8'(a) : big[a-41];
          ci  = 1'((a + k + o) & 1);
          ref_model(3'(k), amt, ci, ops[o], er, ec);
          apply(3'(k), amt, ci, ops[o], er, ec);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule